// File: doc/BRIEF.md
# Register-Triplet Command Packet Engine

The engine receives command packets from a host as a byte-wide valid/ready stream and turns each one into accesses on an internal register port. A packet opens with an opcode byte that chooses between a batch of register writes and a batch of register reads. The next byte is reserved and ignored. After it come up to eight entries of three bytes each: a register address, a data byte and a pad byte. An address byte equal to 0xFE ends the batch early, and everything left in that packet is thrown away.

Accesses are issued one at a time, in the order the entries arrive. Each access is held on the register port until the port acknowledges it. For a read batch, the engine stores each result and, once the batch is over, sends back a fixed 24-byte answer on a separate byte stream. The answer has one three-byte group per entry slot. A malformed opcode makes the engine drop the whole packet and raise a sticky error flag.

Top module: `tpk_engine`

## Requirements
- R1: Opcode 0x99 starts a write batch. Each complete entry produces exactly one register write (`reg_we`=1) carrying the entry's address and data byte, in packet order.
- R2: Opcode 0xDD starts a read batch. Each complete entry produces one register read (`reg_we`=0), in packet order. After the batch, exactly 24 response bytes are sent. Group k occupies bytes 3k..3k+2: the register address at offset 0, the read data at offset 1 and a status byte at offset 2.
- R3: The byte after the opcode has no effect on the batch, whatever its value (including 0x99, 0xDD or 0xFE).
- R4: An address byte of 0xFE ends the batch. No further access is issued for the rest of that packet, and the byte after the packet's last byte is parsed as a new opcode.
- R5: The status byte is 0x04 when the register port flags `reg_empty` on that read's acknowledge, and 0x00 otherwise.
- R6: Response groups for entry slots beyond the last completed entry carry 0xFE in all three bytes. The response is never longer or shorter than 24 bytes.
- R7: An opcode other than 0x99 or 0xDD discards the whole packet, with no access and no response, and sets `err`. Only reset clears `err`.
- R8: After the eighth entry, the batch closes even if `in_last` was not seen. The next input byte is treated as an opcode.
- R9: Only one access is outstanding at a time. `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` stay stable until `reg_ack`.
- R10: While the response is being sent, no input byte is accepted. `rsp_data` stays stable while `rsp_valid` is high and `rsp_ready` is low.
- R11: After reset, `in_ready`=1, `reg_req`=0, `rsp_valid`=0 and `err`=0.
- R12: A packet that ends (`in_last`) before an entry's pad byte drops that partial entry, so it causes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Register port accepts the current access |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |
| reg_empty | input | 1 | Data source empty, valid with `reg_ack` |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Response byte |
| err | output | 1 | Sticky malformed-opcode flag |

## Verification
The hardest case to reach is a batch that closes with no end marker and no `in_last`, because only the entry count decides where the packet stops. The bench sends a full 26-byte write packet with no last flag and follows it at once with a one-entry read packet. That read must come back as a single group followed by filler. Register-port stalls and a toggling response ready are switched on during the full read batch, so that a held access and a held response byte both occur in the middle of a batch. A 0xFE placed in the reserved slot, and a packet that stops partway through an entry, cover the remaining parser corners.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h99;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'hDD;
  localparam logic [BYTE_W-1:0] END_MARK  = 8'hFE;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFE;
  localparam logic [BYTE_W-1:0] ST_EMPTY  = 8'h04;
  localparam logic [BYTE_W-1:0] ST_OK     = 8'h00;

  typedef enum logic [2:0] {
    S_OPC, S_RSV, S_ADDR, S_DATA, S_PAD, S_ACC, S_DRAIN, S_RESP
  } pstate_t;

  // status byte for one read entry
  function automatic logic [BYTE_W-1:0] status_code(input logic empty);
    return empty ? ST_EMPTY : ST_OK;
  endfunction

  // byte at position 'off' within a response group
  function automatic logic [BYTE_W-1:0] group_byte(
      input logic [1:0]        off,
      input logic              filled,
      input logic [BYTE_W-1:0] a,
      input logic [BYTE_W-1:0] d,
      input logic [BYTE_W-1:0] s);
    if (!filled) return FILL_BYTE;
    case (off)
      2'd0:    return a;
      2'd1:    return d;
      2'd2:    return s;
      default: return FILL_BYTE;
    endcase
  endfunction
endpackage

// File: rtl/tpk_parser.sv
module tpk_parser
  import tpk_pkg::*;
#(
  parameter int unsigned N  = 8,
  localparam int unsigned CW = $clog2(N + 1),
  localparam int unsigned EW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              reg_req,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_empty,
  output logic              wr_en,
  output logic [EW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] wr_st,
  output logic [CW-1:0]     ent_cnt,
  output logic              resp_active,
  input  logic              rsp_done,
  output logic              err,
  output logic              ev_access,
  output logic              ev_bad_op
);
  pstate_t           state;
  logic              rd_q, end_q, drop_q, err_q;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] a_q, d_q;
  logic              take, op_ok, op_rd;
  pstate_t           fin;

  always_comb begin
    case (state)
      S_OPC, S_RSV, S_ADDR, S_DATA, S_PAD, S_DRAIN: in_ready = 1'b1;
      default:                                      in_ready = 1'b0;
    endcase
  end

  assign take  = in_valid & in_ready;
  assign op_rd = (in_data == OP_READ);
  assign op_ok = op_rd | (in_data == OP_WRITE);
  assign fin   = rd_q ? S_RESP : S_OPC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_OPC;
      rd_q   <= 1'b0;
      end_q  <= 1'b0;
      drop_q <= 1'b0;
      err_q  <= 1'b0;
      cnt    <= '0;
      a_q    <= '0;
      d_q    <= '0;
    end else begin
      case (state)
        S_OPC: if (take) begin
          if (op_ok) begin
            rd_q  <= op_rd;
            cnt   <= '0;
            state <= in_last ? (op_rd ? S_RESP : S_OPC) : S_RSV;
          end else begin
            err_q  <= 1'b1;
            drop_q <= 1'b1;
            state  <= in_last ? S_OPC : S_DRAIN;
          end
        end
        S_RSV: if (take) state <= in_last ? fin : S_ADDR;
        S_ADDR: if (take) begin
          if (in_data == END_MARK) begin
            drop_q <= 1'b0;
            state  <= in_last ? fin : S_DRAIN;
          end else begin
            a_q   <= in_data;
            state <= in_last ? fin : S_DATA;
          end
        end
        S_DATA: if (take) begin
          d_q   <= in_data;
          state <= in_last ? fin : S_PAD;
        end
        S_PAD: if (take) begin
          end_q <= in_last;
          state <= S_ACC;
        end
        S_ACC: if (reg_ack) begin
          cnt   <= cnt + 1'b1;
          state <= (end_q || cnt == CW'(N - 1)) ? fin : S_ADDR;
        end
        S_DRAIN: if (take && in_last) state <= drop_q ? S_OPC : fin;
        S_RESP:  if (rsp_done) state <= S_OPC;
        default: state <= S_OPC;
      endcase
    end
  end

  assign reg_req     = (state == S_ACC);
  assign reg_we      = reg_req & ~rd_q;
  assign reg_addr    = a_q;
  assign reg_wdata   = d_q;
  assign ev_access   = reg_req & reg_ack;
  assign ev_bad_op   = (state == S_OPC) & take & ~op_ok;
  assign wr_en       = ev_access & rd_q;
  assign wr_idx      = cnt[EW-1:0];
  assign wr_addr     = a_q;
  assign wr_data     = reg_rdata;
  assign wr_st       = status_code(reg_empty);
  assign ent_cnt     = cnt;
  assign resp_active = (state == S_RESP);
  assign err         = err_q;
endmodule

// File: rtl/tpk_rsp_buf.sv
module tpk_rsp_buf
  import tpk_pkg::*;
#(
  parameter int unsigned N  = 8,
  localparam int unsigned CW = $clog2(N + 1),
  localparam int unsigned EW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EW-1:0]     wr_idx,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] wr_st,
  input  logic [CW-1:0]     fill_cnt,
  input  logic              active,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_done
);
  logic [BYTE_W-1:0] a_m [N];
  logic [BYTE_W-1:0] d_m [N];
  logic [BYTE_W-1:0] s_m [N];
  logic [EW-1:0]     grp;
  logic [1:0]        off;
  logic              hs;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_m[g] <= '0;
        d_m[g] <= '0;
        s_m[g] <= '0;
      end else if (wr_en && wr_idx == EW'(g)) begin
        a_m[g] <= wr_addr;
        d_m[g] <= wr_data;
        s_m[g] <= wr_st;
      end
    end
  end

  assign rsp_valid = active;
  assign hs        = rsp_valid & rsp_ready;
  assign rsp_done  = hs & (grp == EW'(N - 1)) & (off == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      grp <= '0;
      off <= '0;
    end else if (hs) begin
      if (off == 2'd2) begin
        off <= '0;
        grp <= rsp_done ? '0 : grp + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end

  assign rsp_data = group_byte(off, CW'(grp) < fill_cnt, a_m[grp], d_m[grp], s_m[grp]);
endmodule

// File: rtl/tpk_engine.sv
module tpk_engine
  import tpk_pkg::*;
#(
  parameter int unsigned MAX_ENT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       reg_req,
  output logic       reg_we,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic       reg_ack,
  input  logic [7:0] reg_rdata,
  input  logic       reg_empty,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       err
);
  localparam int unsigned CW = $clog2(MAX_ENT + 1);
  localparam int unsigned EW = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;

  logic              wr_en, resp_active, rsp_done;
  logic [EW-1:0]     wr_idx;
  logic [BYTE_W-1:0] wr_addr, wr_data, wr_st;
  logic [CW-1:0]     ent_cnt;
  logic              ev_access, ev_bad_op;

  tpk_parser #(.N(MAX_ENT)) u_parse (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .reg_empty(reg_empty),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data), .wr_st(wr_st),
    .ent_cnt(ent_cnt), .resp_active(resp_active), .rsp_done(rsp_done), .err(err),
    .ev_access(ev_access), .ev_bad_op(ev_bad_op)
  );

  tpk_rsp_buf #(.N(MAX_ENT)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data), .wr_st(wr_st),
    .fill_cnt(ent_cnt), .active(resp_active), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_done(rsp_done)
  );
endmodule

// File: rtl/tpk_checker.sv
module tpk_checker #(
  parameter int unsigned N = 8,
  localparam int unsigned RSP_LEN = 3 * N,
  localparam int unsigned RW = $clog2(RSP_LEN + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       reg_req,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_ack,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       err,
  input logic       ev_bad_op
);
  logic [RW-1:0] rb_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !rsp_valid) rb_cnt <= '0;
    else if (rsp_ready)       rb_cnt <= rb_cnt + 1'b1;
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  assert_req_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !rsp_valid && !in_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_no_input_in_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_bad_op_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_op |=> err);

  assert_rsp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rb_cnt < RW'(RSP_LEN));

  assert_rsp_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsp_valid) |-> rb_cnt == RW'(RSP_LEN));
endmodule

bind tpk_engine tpk_checker #(.N(MAX_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_ack(reg_ack), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .err(err), .ev_bad_op(ev_bad_op)
);

// File: tb/tpk_engine_tb_top.sv
`timescale 1ns/1ps
module tpk_engine_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic       in_ready;
  logic       reg_req, reg_we;
  logic [7:0] reg_addr, reg_wdata;
  logic       reg_ack = 0, reg_empty = 0;
  logic [7:0] reg_rdata = 0;
  logic       rsp_valid, rsp_ready = 1;
  logic [7:0] rsp_data;
  logic       err;

  always #4 clk = ~clk;

  tpk_engine dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] pkt [0:31];
  logic [7:0] wr_a [0:63], wr_d [0:63], rd_a [0:63], rb [0:63];
  logic [7:0] exp_a [0:7];
  int wr_n = 0, rd_n = 0, rsp_n = 0;
  bit stall_en = 0, stall_t = 0, rdy_mode = 0, rdy_t = 0;

  function automatic logic [7:0] rd_model(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  function automatic logic emp_model(input logic [7:0] a);
    return a[7:6] == 2'b11;
  endfunction

  // register-port responder
  always @(negedge clk) begin
    if (!rst_n) reg_ack = 0;
    else if (reg_req && !reg_ack) begin
      if (stall_en && !stall_t) stall_t = 1;
      else begin
        stall_t = 0;
        reg_ack = 1;
        reg_rdata = rd_model(reg_addr);
        reg_empty = emp_model(reg_addr);
        if (reg_we) begin
          if (wr_n < 64) begin wr_a[wr_n] = reg_addr; wr_d[wr_n] = reg_wdata; end
          wr_n++;
        end else begin
          if (rd_n < 64) rd_a[rd_n] = reg_addr;
          rd_n++;
        end
      end
    end else reg_ack = 0;
  end

  // response consumer
  always @(negedge clk) begin
    rdy_t = ~rdy_t;
    rsp_ready = rdy_mode ? rdy_t : 1'b1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (rsp_n < 64) rb[rsp_n] = rsp_data;
      rsp_n++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    wr_n = 0; rd_n = 0; rsp_n = 0;
  endtask

  task automatic push(input logic [7:0] b, input logic l);
    @(negedge clk);
    in_valid = 1; in_data = b; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
  endtask

  task automatic send_pkt(input int n, input bit with_last);
    for (int i = 0; i < n; i++) push(pkt[i], with_last && (i == n - 1));
  endtask

  task automatic settle();
    repeat (120) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input int i, input int nent);
    int g = i / 3;
    int o = i % 3;
    if (g >= nent) return 8'hFE;
    if (o == 0) return exp_a[g];
    if (o == 1) return rd_model(exp_a[g]);
    return emp_model(exp_a[g]) ? 8'h04 : 8'h00;
  endfunction

  task automatic check_rsp(input string tag, input int nent);
    check({tag, " rsp length"}, rsp_n, 24);
    for (int i = 0; i < 24; i++) check(tag, rb[i], exp_byte(i, nent));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 in_ready", in_ready, 1);
    check("R11 reg_req", reg_req, 0);
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 err", err, 0);
  endtask

  task automatic t_write_endmark();
    logic [7:0] b [0:13] = '{8'h99, 8'h77, 8'h10, 8'hA1, 8'h00, 8'h22, 8'hB2, 8'h00,
                             8'h34, 8'hC3, 8'h00, 8'hFE, 8'h55, 8'h66};
    clr();
    for (int i = 0; i < 14; i++) pkt[i] = b[i];
    send_pkt(14, 1);
    settle();
    check("R1/R4 write count", wr_n, 3);
    check("R1 w0 addr", wr_a[0], 8'h10); check("R1 w0 data", wr_d[0], 8'hA1);
    check("R1 w1 addr", wr_a[1], 8'h22); check("R1 w1 data", wr_d[1], 8'hB2);
    check("R1 w2 addr", wr_a[2], 8'h34); check("R1 w2 data", wr_d[2], 8'hC3);
    check("R4 no reads", rd_n, 0);
    check("R1 no response", rsp_n, 0);
  endtask

  task automatic t_read_full();
    logic [7:0] a [0:7] = '{8'h01, 8'hC5, 8'h7F, 8'h33, 8'hE0, 8'h42, 8'h80, 8'hFF};
    clr();
    stall_en = 1; rdy_mode = 1;
    pkt[0] = 8'hDD; pkt[1] = 8'h99;
    for (int k = 0; k < 8; k++) begin
      exp_a[k] = a[k];
      pkt[2 + 3*k] = a[k]; pkt[3 + 3*k] = 8'h3C; pkt[4 + 3*k] = 8'h00;
    end
    send_pkt(26, 1);
    settle();
    stall_en = 0; rdy_mode = 0;
    check("R2 read count", rd_n, 8);
    for (int k = 0; k < 8; k++) check("R2/R9 read order", rd_a[k], a[k]);
    check("R2 no writes", wr_n, 0);
    check_rsp("R2/R5/R10 full read", 8);
  endtask

  task automatic t_read_short();
    logic [7:0] b [0:8] = '{8'hDD, 8'hFE, 8'hC0, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'hFE};
    clr();
    exp_a[0] = 8'hC0; exp_a[1] = 8'h12;
    for (int i = 0; i < 9; i++) pkt[i] = b[i];
    send_pkt(9, 1);
    settle();
    check("R3 reserved 0xFE ignored, reads", rd_n, 2);
    check_rsp("R6/R5 filler after end marker", 2);
  endtask

  task automatic t_bad_op();
    logic [7:0] b [0:7] = '{8'h42, 8'h00, 8'h10, 8'h11, 8'h00, 8'h20, 8'h21, 8'h00};
    clr();
    for (int i = 0; i < 8; i++) pkt[i] = b[i];
    send_pkt(8, 1);
    settle();
    check("R7 no writes", wr_n, 0);
    check("R7 no reads", rd_n, 0);
    check("R7 no response", rsp_n, 0);
    check("R7 err set", err, 1);
    check("R7 ready again", in_ready, 1);
  endtask

  task automatic t_eight_no_last();
    clr();
    pkt[0] = 8'h99; pkt[1] = 8'h00;
    for (int k = 0; k < 8; k++) begin
      pkt[2 + 3*k] = 8'h40 + 8'(k); pkt[3 + 3*k] = 8'hB0 + 8'(k); pkt[4 + 3*k] = 8'h00;
    end
    send_pkt(26, 0);
    pkt[0] = 8'hDD; pkt[1] = 8'h00; pkt[2] = 8'h05; pkt[3] = 8'h00; pkt[4] = 8'h00;
    exp_a[0] = 8'h05;
    send_pkt(5, 1);
    settle();
    check("R8 write count", wr_n, 8);
    for (int k = 0; k < 8; k++) begin
      check("R8 write addr", wr_a[k], 8'h40 + k);
      check("R8 write data", wr_d[k], 8'hB0 + k);
    end
    check("R8 next opcode read count", rd_n, 1);
    check_rsp("R8/R6 one-entry response", 1);
  endtask

  task automatic t_partial();
    clr();
    pkt[0] = 8'h99; pkt[1] = 8'h00; pkt[2] = 8'h20; pkt[3] = 8'h21;
    send_pkt(4, 1);
    settle();
    check("R12 partial entry dropped", wr_n, 0);
    pkt[4] = 8'h00;
    send_pkt(5, 1);
    settle();
    check("R12 recovery write count", wr_n, 1);
    check("R12 recovery addr", wr_a[0], 8'h20);
    check("R7 err still set", err, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_endmark();
    t_read_full();
    t_read_short();
    t_bad_op();
    t_eight_no_last();
    t_partial();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule